// File: doc/BRIEF.md
# Message Interrupt Source State Unit

This block keeps the per-source state for a small array of message-signalled interrupt sources. It decides when each source is offered to a downstream presentation controller. For every source it holds a priority, a two-bit presented/queued state, a flag that remembers an event that arrived while the source was masked, and a flag that marks a failed delivery for later replay. The presentation controller reports back through the same event port. It signals deliveries that it could not take, and it hands back interrupts that it displaced.

Events enter one per cycle over a valid/ready port. Each event carries a kind, a global source number and a priority value. Source numbers are a fixed base plus a local index. A delivery leaves on a second valid/ready port as a source number and a priority. While a delivery waits to be taken, or while a resend scan is running, the event port is not ready. A single output bit reports that this unit has sources waiting for a resend scan.

Top module: `irq_source_unit`

## Requirements
- R1: After reset every source has state 00, both flags clear and priority 0xFF. `dlv_valid` and `resend_map` are low, and `ev_ready` is high.
- R2: A message event (kind 0) sets the source state to {old bit0, 1}, with bit0 = presented (P) and bit1 = queued (Q). A delivery attempt follows only when the new state is exactly 2'b01.
- R3: An end-of-interrupt event (kind 1) shifts the state right by one, so Q moves into P and Q clears. A delivery attempt follows when the new P is 1.
- R4: A delivery attempt for a source whose priority is 0xFF issues nothing and sets its masked-pending flag. A priority event (kind 4) stores `ev_prio`. When that value is not 0xFF and the flag is set, the flag clears and one delivery goes out at the new priority.
- R5: A delivery-failed event (kind 2) sets the source's resend flag and drives `resend_map` high.
- R6: A scan event (kind 5, number ignored) clears `resend_map`. It then makes a delivery attempt for every source with its resend flag set, one at a time in ascending index order, and clears each flag.
- R7: A rejection event (kind 3) is a delivery attempt for that source at its stored priority. Its resend flag is cleared first.
- R8: Events whose number lies outside BASE to BASE+15, and events of kinds 6 and 7, change no state and produce no delivery.
- R9: A delivery holds its number and priority stable until `dlv_ready` is high. `ev_ready` is low while a delivery is pending or a scan is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Event accepted this cycle when valid |
| ev_kind | input | 3 | Event kind code |
| ev_num | input | NUM_W | Global source number |
| ev_prio | input | PRIO_W | Priority for kind 4 |
| dlv_valid | output | 1 | Delivery request pending |
| dlv_ready | input | 1 | Presenter takes the delivery |
| dlv_num | output | NUM_W | Delivered source number |
| dlv_prio | output | PRIO_W | Delivered priority |
| resend_map | output | 1 | Unit has sources flagged for resend |

## Verification
The assertions assume that the presenter only drops `dlv_ready` and never withdraws a taken delivery. They also assume that `ev_valid` and its fields are driven cleanly between clock edges. The stimulus honours this by driving every input at the falling edge and by holding each event until it is accepted. Random traffic mixes in-range and out-of-range numbers and masked and unmasked priorities, and it applies back-pressure on `dlv_ready`. A reference model in the bench predicts the ordered list of deliveries.

// File: rtl/irq_source_unit.sv
module irq_source_unit #(
  parameter int NSRC   = 16,
  parameter int NUM_W  = 12,
  parameter int PRIO_W = 8,
  parameter logic [NUM_W-1:0] BASE = 12'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [2:0]        ev_kind,
  input  logic [NUM_W-1:0]  ev_num,
  input  logic [PRIO_W-1:0] ev_prio,
  output logic              dlv_valid,
  input  logic              dlv_ready,
  output logic [NUM_W-1:0]  dlv_num,
  output logic [PRIO_W-1:0] dlv_prio,
  output logic              resend_map
);
  localparam int IDX_W = $clog2(NSRC);
  localparam logic [PRIO_W-1:0] MASKED = '1;
  localparam logic [2:0] K_MSG = 3'd0, K_EOI = 3'd1, K_FAIL = 3'd2,
                         K_REJ = 3'd3, K_PRIO = 3'd4, K_SCAN = 3'd5;

  logic [1:0]        pq   [NSRC];
  logic [PRIO_W-1:0] prio [NSRC];
  logic [NSRC-1:0]   rs, mp;
  logic              scanning;

  logic [NUM_W-1:0] rel;
  logic [IDX_W-1:0] idx, low, try_idx;
  logic             in_rng, accept, hit, found, try_en;

  assign rel      = ev_num - BASE;
  assign in_rng   = (ev_num >= BASE) && (rel < NUM_W'(NSRC));
  assign idx      = rel[IDX_W-1:0];
  assign ev_ready = !dlv_valid && !scanning;
  assign accept   = ev_valid && ev_ready;
  assign hit      = accept && in_rng;

  always_comb begin
    found = 1'b0;
    low   = '0;
    for (int i = NSRC-1; i >= 0; i--)
      if (rs[i]) begin
        found = 1'b1;
        low   = IDX_W'(i);
      end
  end

  always_comb begin
    try_en  = 1'b0;
    try_idx = idx;
    if (hit) begin
      case (ev_kind)
        K_MSG:   try_en = !pq[idx][0];
        K_EOI:   try_en = pq[idx][1];
        K_REJ:   try_en = 1'b1;
        default: try_en = 1'b0;
      endcase
    end else if (scanning && !dlv_valid && found) begin
      try_en  = 1'b1;
      try_idx = low;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) begin
        pq[i]   <= 2'b00;
        prio[i] <= MASKED;
      end
      rs         <= '0;
      mp         <= '0;
      scanning   <= 1'b0;
      resend_map <= 1'b0;
      dlv_valid  <= 1'b0;
      dlv_num    <= '0;
      dlv_prio   <= '0;
    end else begin
      if (dlv_valid && dlv_ready) dlv_valid <= 1'b0;
      if (hit) begin
        case (ev_kind)
          K_MSG:  pq[idx] <= {pq[idx][0], 1'b1};
          K_EOI:  pq[idx] <= {1'b0, pq[idx][1]};
          K_FAIL: begin
            rs[idx]    <= 1'b1;
            resend_map <= 1'b1;
          end
          K_PRIO: begin
            prio[idx] <= ev_prio;
            if (mp[idx] && ev_prio != MASKED) begin
              mp[idx]   <= 1'b0;
              dlv_valid <= 1'b1;
              dlv_num   <= ev_num;
              dlv_prio  <= ev_prio;
            end
          end
          default: ;
        endcase
      end
      if (accept && ev_kind == K_SCAN) begin
        scanning   <= 1'b1;
        resend_map <= 1'b0;
      end else if (scanning && !dlv_valid && !found) begin
        scanning <= 1'b0;
      end
      if (try_en) begin
        rs[try_idx] <= 1'b0;
        if (prio[try_idx] == MASKED) mp[try_idx] <= 1'b1;
        else begin
          dlv_valid <= 1'b1;
          dlv_num   <= BASE + NUM_W'(try_idx);
          dlv_prio  <= prio[try_idx];
        end
      end
    end
  end

  AST_DLV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid && !dlv_ready |=> dlv_valid && $stable(dlv_num) && $stable(dlv_prio)); // R9
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> !ev_ready); // R9
  AST_NO_MASKED_DLV: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> dlv_prio != MASKED); // R4
  AST_DLV_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> (dlv_num >= BASE) && (dlv_num - BASE < NUM_W'(NSRC))); // R8
  AST_FAIL_SETS_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_ready && ev_kind == K_FAIL && in_rng |=> resend_map); // R5
  AST_SCAN_CLEARS_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_ready && ev_kind == K_SCAN |=> !resend_map); // R6
endmodule

// File: tb/irq_source_unit_test.sv
`timescale 1ns/1ps
module irq_source_unit_test;
  localparam int NSRC = 16;
  localparam logic [11:0] BASE = 12'h100;

  logic clk = 0, rst_n = 0;
  logic ev_valid = 0, dlv_ready = 0;
  logic ev_ready, dlv_valid, resend_map;
  logic [2:0]  ev_kind = 0;
  logic [11:0] ev_num = 0, dlv_num;
  logic [7:0]  ev_prio = 0, dlv_prio;

  irq_source_unit uut (.clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_kind(ev_kind), .ev_num(ev_num), .ev_prio(ev_prio), .dlv_valid(dlv_valid),
    .dlv_ready(dlv_ready), .dlv_num(dlv_num), .dlv_prio(dlv_prio), .resend_map(resend_map));

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  logic [1:0] m_pq [NSRC];
  logic [7:0] m_pr [NSRC];
  logic m_rs [NSRC];
  logic m_mp [NSRC];
  logic m_map;
  logic [19:0] expq [$];
  logic stall_en = 0;
  bit done = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic attempt(input int i);
    m_rs[i] = 0;
    if (m_pr[i] == 8'hFF) m_mp[i] = 1;
    else expq.push_back({BASE + 12'(i), m_pr[i]});
  endtask

  task automatic model(input logic [2:0] k, input logic [11:0] n, input logic [7:0] p);
    int i;
    bit ok;
    i = int'(n) - int'(BASE);
    ok = (i >= 0) && (i < NSRC);
    if (k == 3'd5) begin
      m_map = 0;
      for (int j = 0; j < NSRC; j++) if (m_rs[j]) attempt(j);
    end else if (ok) begin
      case (k)
        3'd0: begin m_pq[i] = {m_pq[i][0], 1'b1}; if (m_pq[i] == 2'b01) attempt(i); end
        3'd1: begin m_pq[i] = {1'b0, m_pq[i][1]}; if (m_pq[i][0]) attempt(i); end
        3'd2: begin m_rs[i] = 1; m_map = 1; end
        3'd3: attempt(i);
        3'd4: begin
          m_pr[i] = p;
          if (m_mp[i] && p != 8'hFF) begin m_mp[i] = 0; expq.push_back({n, p}); end
        end
        default: ;
      endcase
    end
  endtask

  task automatic send(input string tag, input logic [2:0] k, input logic [11:0] n, input logic [7:0] p);
    @(negedge clk);
    while (!ev_ready) @(negedge clk);
    ev_valid = 1; ev_kind = k; ev_num = n; ev_prio = p;
    model(k, n, p);
    @(negedge clk);
    ev_valid = 0;
    while (!ev_ready) @(negedge clk);
    check({tag, " deliveries outstanding"}, 32'(expq.size()), 0);
    check({tag, " resend_map"}, 32'(resend_map), 32'(m_map));
  endtask

  always @(negedge clk) begin
    dlv_ready = stall_en ? ($urandom % 4 != 0) : 1'b1;
    if (rst_n && dlv_valid && dlv_ready) begin
      if (expq.size() == 0) check("R9 unexpected delivery", {dlv_num, dlv_prio}, 32'hFFFFFFFF);
      else check("R9 delivery content", {12'h0, dlv_num, dlv_prio}, {12'h0, expq.pop_front()});
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NSRC; i++) begin m_pq[i] = 0; m_pr[i] = 8'hFF; m_rs[i] = 0; m_mp[i] = 0; end
    m_map = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 ev_ready", 32'(ev_ready), 1);
    check("R1 dlv_valid", 32'(dlv_valid), 0);
    check("R1 resend_map", 32'(resend_map), 0);
    send("R1 reset masked", 3'd0, BASE + 12'd5, 0);
    send("R2 set prio", 3'd4, BASE + 12'd3, 8'd5);
    send("R2 first message", 3'd0, BASE + 12'd3, 0);
    send("R2 queued message", 3'd0, BASE + 12'd3, 0);
    send("R3 eoi re-present", 3'd1, BASE + 12'd3, 0);
    send("R3 eoi idle", 3'd1, BASE + 12'd3, 0);
    send("R4 masked message", 3'd0, BASE + 12'd7, 0);
    send("R4 unmask release", 3'd4, BASE + 12'd7, 8'd9);
    send("R5 fail a", 3'd2, BASE + 12'd9, 0);
    send("R5 fail b", 3'd2, BASE + 12'd2, 0);
    send("R6 prio a", 3'd4, BASE + 12'd9, 8'd3);
    send("R6 prio b", 3'd4, BASE + 12'd2, 8'd1);
    send("R6 scan ascending", 3'd5, 0, 0);
    send("R6 scan empty", 3'd5, 0, 0);
    send("R7 reject", 3'd3, BASE + 12'd3, 0);
    send("R8 out of range high", 3'd3, BASE + 12'd16, 0);
    send("R8 out of range low", 3'd3, BASE - 12'd1, 0);
    send("R8 unused kind", 3'd6, BASE + 12'd3, 0);
    stall_en = 1;
    for (int t = 0; t < 3000; t++) begin
      int r;
      logic [2:0] k;
      logic [11:0] n;
      logic [7:0] p;
      r = $urandom % 20;
      k = (r < 7) ? 3'd0 : (r < 11) ? 3'd1 : (r < 13) ? 3'd2 : (r < 15) ? 3'd3 :
          (r < 18) ? 3'd4 : (r < 19) ? 3'd5 : 3'd7;
      n = ($urandom % 10 == 0) ? BASE + 12'(16 + $urandom % 4) : BASE + 12'($urandom % 16);
      p = ($urandom % 4 == 0) ? 8'hFF : 8'($urandom % 255);
      send("R9 random traffic", k, n, p);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule